// File: doc/BRIEF.md
# Register-Map I2C Slave

This block sits on a two-wire I2C bus, clocked at up to 400 kHz, and gives a bus master read and write access to a byte-wide register map of 256 locations. The master first sends a one-byte sub-address, which loads an internal pointer. Each data byte that follows is written at the pointer, and the pointer then advances. Reads use the combined format: the sub-address is written first, then a repeated START follows with the read bit set. The slave returns bytes from the pointer onward until the master NACKs.

The map has four kinds of location. Writable configuration bytes are held in flops and are also visible to on-chip logic through a side read port. Read-only status bytes reflect an input bus. One error-flag byte is set by a hardware pulse and clears once the master has read it. Unassigned holes read as zero and absorb writes. Both bus lines pass through a flop synchroniser into the system clock, and START and STOP are found from SDA edges while SCL is high.

Top module: `regmap_i2c_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0111101 (address byte 7Ah for a write, 7Bh for a read) by pulling SDA low in the ninth clock. Any other address is NACKed, and the rest of that transfer changes no register.
- R2: In a write transfer the first byte after the address loads the sub-address pointer. Every later byte is stored at the pointer. Each byte is ACKed.
- R3: In a read transfer the slave sends bytes MSB first from the pointer. It goes on while the master ACKs, stops after a NACK, and changes SDA only while SCL is low.
- R4: The pointer advances by one after every data byte, in reads and in writes, and wraps from FFh to 00h.
- R5: Addresses E0h–EFh, F4h–F7h and F9h–FFh are unassigned. They read as 00h, and writes to them are ACKed but stored nowhere.
- R6: Addresses F0h–F3h are read-only. Address F0h+i returns status input bits [8i+7:8i]. Writes to these addresses are ACKed and ignored.
- R7: Address F8h returns the error flag in bit 0 (other bits 0). A pulse on the error input sets the flag. The flag clears once its byte has been sent to the master, unless a new pulse arrives in the same cycle.
- R8: After reset every writable register (00h–DFh) holds 00h, the pointer is 00h and SDA is released.
- R9: The side read port returns, combinationally, the byte that a bus read of the given address would return. Reading the error flag through this port does not clear it.
- R10: A STOP ends any transfer, including one in the middle of a byte. A START or repeated START at any point begins a new address phase, and the pointer is kept across it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| status_in | input | 32 | Read-only status bytes, byte i at address F0h+i |
| err_set | input | 1 | One-cycle pulse that sets the error flag |
| cfg_addr | input | 8 | Side read port address |
| cfg_data | output | 8 | Side read port data |

## Verification
The assertions assume that the master obeys bus timing. SDA moves only while SCL is low, except on purpose for START and STOP. Each SCL level also lasts many system clocks, so a rise or fall is seen cleanly after the synchroniser. The bench keeps to this by driving each bus phase for sixteen system clocks and changing SDA only a quarter bit after an SCL edge. It also keeps the error pulse and the side read port away from bus transfers, except where a requirement asks for their interaction. A behavioural model of the map is compared with the side read port on every idle clock. Each bus read is checked against that same model.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      KIND_NONE,
      KIND_RW,
      KIND_RO,
      KIND_FLAG
   } reg_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bus_state_e;

   typedef enum logic [1:0] {
      RX_DEV,
      RX_SUB,
      RX_DATA
   } rx_phase_e;

   // Classify one map location from the layout parameters.
   function automatic reg_kind_e kind_of(input int a, input int rw_lim,
                                         input int ro_base, input int ro_n,
                                         input int flag_a);
      if (a < rw_lim)                           return KIND_RW;
      if (a == flag_a)                          return KIND_FLAG;
      if (a >= ro_base && a < ro_base + ro_n)   return KIND_RO;
      return KIND_NONE;
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[STAGES-2:0], sda_i};
         scl_q     <= scl_chain[STAGES-1];
         sda_q     <= sda_chain[STAGES-1];
      end
   end

   assign scl_s     = scl_chain[STAGES-1];
   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b0111101,
   parameter int         AW       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [AW-1:0]     ptr,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              take,
   output logic [AW-1:0]     take_addr
);

   bus_state_e        state;
   rx_phase_e         phase;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx_sh;
   logic              rw;
   logic              nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= RX_DEV;
         cnt       <= '0;
         sh        <= '0;
         tx_sh     <= '0;
         rw        <= 1'b0;
         nack      <= 1'b0;
         ptr       <= '0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         take      <= 1'b0;
         take_addr <= '0;
      end else begin
         wr_en <= 1'b0;
         take  <= 1'b0;
         if (start_det) begin
            state  <= ST_RX;
            phase  <= RX_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && cnt != 4'd8) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     case (phase)
                        RX_DEV: begin
                           if (sh[7:1] == DEV_ADDR) begin
                              rw     <= sh[0];
                              sda_oe <= 1'b1;
                              state  <= ST_ACK;
                           end else begin
                              state  <= ST_IDLE;
                           end
                        end
                        RX_SUB: begin
                           ptr    <= sh[AW-1:0];
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= sh;
                           ptr     <= ptr + 1'b1;
                           sda_oe  <= 1'b1;
                           state   <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (phase == RX_DEV && rw) begin
                        tx_sh     <= rd_data;
                        sda_oe    <= ~rd_data[BYTE_W-1];
                        cnt       <= '0;
                        take      <= 1'b1;
                        take_addr <= ptr;
                        ptr       <= ptr + 1'b1;
                        state     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                        phase  <= (phase == RX_DEV) ? RX_SUB : RX_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_MACK;
                     end else begin
                        sda_oe <= ~tx_sh[BYTE_W-2];
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        state <= ST_IDLE;
                     end else begin
                        tx_sh     <= rd_data;
                        sda_oe    <= ~rd_data[BYTE_W-1];
                        cnt       <= '0;
                        take      <= 1'b1;
                        take_addr <= ptr;
                        ptr       <= ptr + 1'b1;
                        state     <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2
   wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (state == ST_ACK && sda_oe));

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == AW'(wr_addr + 1'b1)));

   // R3
   oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |->
         ($past(scl_fall) || $past(start_det) || $past(stop_det)));

   // R10
   start_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_RX && phase == RX_DEV && !sda_oe && cnt == 4'd0));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_rf_pkg::*;
#(
   parameter int AW        = 8,
   parameter int RW_LIMIT  = 'hE0,
   parameter int RO_BASE   = 'hF0,
   parameter int RO_COUNT  = 4,
   parameter int FLAG_ADDR = 'hF8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic                       take,
   input  logic [AW-1:0]              take_addr,
   input  logic                       err_set,
   input  logic [BYTE_W*RO_COUNT-1:0] status_in,
   input  logic [AW-1:0]              rd_addr,
   input  logic [AW-1:0]              cfg_addr,
   output logic [BYTE_W-1:0]          rd_data,
   output logic [BYTE_W-1:0]          cfg_data
);

   localparam int DEPTH = 1 << AW;

   logic [BYTE_W-1:0] val [DEPTH];
   logic              flag_q;

   for (genvar a = 0; a < DEPTH; a++) begin : g_loc
      localparam reg_kind_e K = kind_of(a, RW_LIMIT, RO_BASE, RO_COUNT, FLAG_ADDR);
      if (K == KIND_RW) begin : g_rw
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             q <= '0;
            else if (wr_en && wr_addr == AW'(a))    q <= wr_data;
         end
         assign val[a] = q;
      end else if (K == KIND_RO) begin : g_ro
         assign val[a] = status_in[(a - RO_BASE) * BYTE_W +: BYTE_W];
      end else if (K == KIND_FLAG) begin : g_flag
         assign val[a] = {{(BYTE_W-1){1'b0}}, flag_q};
      end else begin : g_hole
         assign val[a] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        flag_q <= 1'b0;
      else if (err_set)                                  flag_q <= 1'b1;
      else if (take && take_addr == AW'(FLAG_ADDR))      flag_q <= 1'b0;
   end

   assign rd_data  = val[rd_addr];
   assign cfg_data = val[cfg_addr];

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_addr == AW'(FLAG_ADDR) && !err_set) |=> (val[FLAG_ADDR] == '0));

   // R7
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> (val[FLAG_ADDR][0] == 1'b1));

endmodule

// File: rtl/regmap_i2c_slave.sv
module regmap_i2c_slave
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b0111101,
   parameter int         AW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         RW_LIMIT    = 'hE0,
   parameter int         RO_BASE     = 'hF0,
   parameter int         RO_COUNT    = 4,
   parameter int         FLAG_ADDR   = 'hF8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   input  logic [BYTE_W*RO_COUNT-1:0] status_in,
   input  logic                       err_set,
   input  logic [AW-1:0]              cfg_addr,
   output logic [BYTE_W-1:0]          cfg_data
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
      initial $error("AW must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $error("SYNC_STAGES must be at least 2");
   end
   if (RW_LIMIT > RO_BASE || RO_BASE + RO_COUNT > FLAG_ADDR || FLAG_ADDR >= DEPTH) begin : g_bad_map
      initial $error("register layout parameters overlap or exceed the map");
   end

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [BYTE_W-1:0] rd_data;
   logic [AW-1:0]     ptr;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic              take;
   logic [AW-1:0]     take_addr;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_bus_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .take      (take),
      .take_addr (take_addr)
   );

   i2c_reg_bank #(
      .AW        (AW),
      .RW_LIMIT  (RW_LIMIT),
      .RO_BASE   (RO_BASE),
      .RO_COUNT  (RO_COUNT),
      .FLAG_ADDR (FLAG_ADDR)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .take      (take),
      .take_addr (take_addr),
      .err_set   (err_set),
      .status_in (status_in),
      .rd_addr   (ptr),
      .cfg_addr  (cfg_addr),
      .rd_data   (rd_data),
      .cfg_data  (cfg_data)
   );

endmodule

// File: tb/regmap_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module regmap_i2c_slave_tb_top;

   localparam int         Q      = 16;
   localparam logic [7:0] DEV_W  = 8'h7A;
   localparam logic [7:0] DEV_R  = 8'h7B;
   localparam logic [31:0] STAT  = 32'hD4C3B2A1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_lo = 1'b0;
   logic       sda_line;
   logic       sda_oe;
   logic       err_set = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic [7:0] cfg_data;

   int  checks = 0;
   int  fails  = 0;
   bit  cmp_en = 1'b0;
   bit  done   = 1'b0;

   logic [7:0] mdl [256];
   bit         mflag = 1'b0;
   logic [7:0] mptr  = 8'h00;

   always #2.5 clk = ~clk;

   assign sda_line = ~(sda_lo | sda_oe);

   regmap_i2c_slave dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .status_in (STAT),
      .err_set   (err_set),
      .cfg_addr  (cfg_addr),
      .cfg_data  (cfg_data)
   );

   // Behavioural map model from the requirements (R5, R6, R7).
   function automatic logic [7:0] model_read(input logic [7:0] a);
      if (a < 8'hE0)                 return mdl[a];
      if (a == 8'hF8)                return {7'd0, mflag};
      if (a >= 8'hF0 && a <= 8'hF3)  return STAT[(a - 8'hF0) * 8 +: 8];
      return 8'h00;
   endfunction

   function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
      if (a < 8'hE0) mdl[a] = d;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   // Side port compared with the model on every idle clock (R9).
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         checks++;
         if (cfg_data !== model_read(cfg_addr)) begin
            fails++;
            $display("FAIL R9: cfg_data at %02h got %02h expected %02h",
                     cfg_addr, cfg_data, model_read(cfg_addr));
         end
      end
   end

   task automatic qw();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic i2c_start();
      sda_lo = 1'b0; qw();
      scl = 1'b1;    qw();
      sda_lo = 1'b1; qw();
      scl = 1'b0;    qw();
   endtask

   task automatic i2c_stop();
      sda_lo = 1'b1; qw();
      scl = 1'b1;    qw();
      sda_lo = 1'b0; qw();
   endtask

   task automatic send_bit(input logic b);
      sda_lo = ~b; qw();
      scl = 1'b1;  qw(); qw();
      scl = 1'b0;  qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_lo = 1'b0; qw();
      scl = 1'b1;    qw();
      acked = (sda_line == 1'b0);
      qw();
      scl = 1'b0;    qw();
   endtask

   task automatic read_byte(output logic [7:0] b, input bit nack);
      sda_lo = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         qw();
         scl = 1'b1; qw();
         b[i] = sda_line;
         qw();
         scl = 1'b0;
      end
      qw();
      sda_lo = ~nack; qw();
      scl = 1'b1;     qw(); qw();
      scl = 1'b0;     qw();
      sda_lo = 1'b0;
   endtask

   task automatic wr_seq(input logic [7:0] sub, input logic [7:0] data [$], input string tag);
      logic ak;
      cmp_en = 1'b0;
      i2c_start();
      send_byte(DEV_W, ak); chk(ak, "R1", {7'd0, ak}, 8'd1);
      send_byte(sub, ak);   chk(ak, tag, {7'd0, ak}, 8'd1);
      mptr = sub;
      foreach (data[k]) begin
         send_byte(data[k], ak);
         chk(ak, tag, {7'd0, ak}, 8'd1);
         model_write(mptr, data[k]);
         mptr++;
      end
      i2c_stop();
      qw();
      cmp_en = 1'b1;
   endtask

   task automatic rd_seq(input logic [7:0] sub, input int n, input string tag);
      logic       ak;
      logic [7:0] got;
      logic [7:0] exp;
      cmp_en = 1'b0;
      i2c_start();
      send_byte(DEV_W, ak); chk(ak, "R1", {7'd0, ak}, 8'd1);
      send_byte(sub, ak);   chk(ak, "R2", {7'd0, ak}, 8'd1);
      mptr = sub;
      i2c_start();
      send_byte(DEV_R, ak); chk(ak, "R1", {7'd0, ak}, 8'd1);
      for (int k = 0; k < n; k++) begin
         exp = model_read(mptr);
         read_byte(got, k == n - 1);
         chk(got === exp, tag, got, exp);
         if (mptr == 8'hF8) mflag = 1'b0;
         mptr++;
      end
      i2c_stop();
      qw();
      cmp_en = 1'b1;
   endtask

   task automatic sweep();
      for (int a = 0; a < 256; a++) begin
         @(posedge clk); #1;
         cfg_addr = 8'(a);
      end
      @(posedge clk); #1;
   endtask

   initial begin
      logic       ak;
      logic [7:0] got;
      for (int a = 0; a < 256; a++) mdl[a] = 8'h00;

      repeat (5) @(posedge clk);
      #1;
      chk(sda_oe == 1'b0, "R8", {7'd0, sda_oe}, 8'd0);
      rst_n = 1'b1;
      qw();
      cfg_addr = 8'h10; #1;
      chk(cfg_data == 8'h00, "R8", cfg_data, 8'h00);
      cmp_en = 1'b1;
      sweep();

      // Burst write and combined read (R2, R3)
      wr_seq(8'h10, '{8'hA5, 8'h5A, 8'h3C}, "R2");
      sweep();
      rd_seq(8'h10, 3, "R3");

      // Foreign address is NACKed and has no effect (R1)
      cmp_en = 1'b0;
      i2c_start();
      send_byte(8'h78, ak); chk(!ak, "R1", {7'd0, ak}, 8'd0);
      send_byte(8'h10, ak);
      send_byte(8'hFF, ak);
      i2c_stop(); qw();
      cmp_en = 1'b1;
      cfg_addr = 8'h10; #1;
      chk(cfg_data == 8'hA5, "R1", cfg_data, 8'hA5);
      rd_seq(8'h10, 1, "R1");

      // Read-only status (R6)
      wr_seq(8'hF0, '{8'hFF, 8'hEE}, "R6");
      rd_seq(8'hF0, 4, "R6");

      // Unassigned holes (R5)
      wr_seq(8'hE5, '{8'h77}, "R5");
      rd_seq(8'hE4, 2, "R5");
      wr_seq(8'hFA, '{8'h12}, "R5");
      rd_seq(8'hF6, 2, "R5");

      // Pointer wrap (R4)
      wr_seq(8'hFD, '{8'h11, 8'h22, 8'h33, 8'h44}, "R4");
      cfg_addr = 8'h00; #1;
      chk(cfg_data == 8'h44, "R4", cfg_data, 8'h44);
      rd_seq(8'hFF, 3, "R4");

      // Error flag: side port does not clear, bus read does (R7, R9)
      @(posedge clk); #1; err_set = 1'b1;
      @(posedge clk); #1; err_set = 1'b0; mflag = 1'b1;
      sweep();
      cfg_addr = 8'hF8; #1;
      chk(cfg_data == 8'h01, "R9", cfg_data, 8'h01);
      rd_seq(8'hF8, 1, "R7");
      rd_seq(8'hF8, 1, "R7");

      // Repeated start keeps the pointer; STOP mid-byte aborts (R10)
      wr_seq(8'h21, '{8'h9C}, "R2");
      cmp_en = 1'b0;
      i2c_start();
      send_byte(DEV_W, ak); chk(ak, "R10", {7'd0, ak}, 8'd1);
      send_byte(8'h20, ak); chk(ak, "R10", {7'd0, ak}, 8'd1);
      send_byte(8'h6E, ak); chk(ak, "R10", {7'd0, ak}, 8'd1);
      model_write(8'h20, 8'h6E);
      i2c_start();
      send_byte(DEV_R, ak); chk(ak, "R10", {7'd0, ak}, 8'd1);
      read_byte(got, 1'b1);
      chk(got === 8'h9C, "R10", got, 8'h9C);
      i2c_stop(); qw();
      i2c_start();
      send_byte(DEV_W, ak);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      i2c_stop(); qw();
      chk(sda_oe == 1'b0, "R10", {7'd0, sda_oe}, 8'd0);
      cmp_en = 1'b1;
      rd_seq(8'h20, 2, "R10");
      sweep();

      cmp_en = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R10: got hung run expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule